// File: doc/BRIEF.md
# Prescaled 64-bit Compare Timer

This block is a memory-mapped timer peripheral with a 32-bit word register interface. It keeps a 64-bit count that moves only while the run bit in the control register is set. A 12-bit prescaler sets the pace. Each time the prescaler wraps, the count grows by an 8-bit programmable increment. The count is checked against a 64-bit compare value on every clock.

The block has two interrupt outputs:
- A raw timer line. It follows the result of the comparison while the timer runs.
- A peripheral interrupt. It is latched in a status bit, gated by an enable bit and cleared by writing ones. Software can also raise it through a write-only test register.

Bus accesses are single-cycle. A write takes effect at the clock edge where the request is valid. Read data is combinational from the address.

Top module: `tick_timer64`

## Requirements
- R1: Reset values:
  - The control register reads 0.
  - The configuration register reads 0x00010000 (increment 1, prescale 0).
  - Both compare words read 0xFFFFFFFF.
  - Interrupt enable and interrupt status read 0.
  - `mtip_o` and `irq_o` are 0.
- R2: Byte offsets:
  - Control is at 0x004, with the run bit at bit 0.
  - Configuration is at 0x100.
  - The count low and high words are at 0x104 and 0x108.
  - The compare low and high words are at 0x10C and 0x110.
  - Enable is at 0x114, status at 0x118 and test at 0x11C.
  - In the configuration register, the prescale is bits [11:0] and the increment is bits [23:16]. All other configuration bits read 0.
- R3: While the run bit is 0, the count does not change and neither interrupt output changes.
- R4: The prescaler is held at zero while the timer is stopped. With prescale N, the first tick comes N+1 running cycles after the run bit is set, and ticks then repeat every N+1 cycles.
- R5: Each tick adds the increment to the 64-bit count. Writes to the count words are ignored.
- R6: While the timer runs, `mtip_o` is a register that takes the value of (count >= compare) at every edge. It therefore rises one cycle after the count reaches the compare value. It falls one cycle after the compare value is moved above the count.
- R7: At an edge where the timer runs, the comparison is true and enable bit 0 is 1, status bit 0 is set. `irq_o` is 1 exactly when status bit 0 and enable bit 0 are both 1.
- R8: A write to status clears each bit that is written as 1 and leaves the others unchanged. A set event in the same cycle wins over the clear.
- R9: Writing 1 to test bit 0 sets status bit 0 only when enable bit 0 is 1. The test register reads 0.
- R10: Clearing enable bit 0 forces `irq_o` to 0 but keeps the latched status. Setting the enable again brings the interrupt back.
- R11: Offsets that are not mapped read 0. Writes to them change nothing.
- R12: A write to either compare word is used in the comparison from the next cycle. This holds even when only one half has been written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational) |
| mtip_o | output | 1 | Raw compare interrupt |
| irq_o | output | 1 | Enabled, latched peripheral interrupt |

## Verification
The counter is run with two configurations:
- Prescale 3 with increment 5. The count after a known number of running cycles shows whether the first tick is placed correctly and whether the increment is applied per tick.
- Prescale 0 with increment 1. Here the count value seen when `mtip_o` first rises pins the one-cycle compare latency.

The compare value is moved in three ways:
- while stopped, to prove the interrupts are frozen;
- while running, to show the raw line dropping;
- one half at a time, to show that a partial update already takes effect.

Status is driven from three sources: a compare event, the test register with enable off, and the test register with enable on. These separate the gating by the enable from the latching in status.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int OFF_CTRL   = 'h004;
  localparam int OFF_CFG    = 'h100;
  localparam int OFF_CNT_LO = 'h104;
  localparam int OFF_CNT_HI = 'h108;
  localparam int OFF_CMP_LO = 'h10C;
  localparam int OFF_CMP_HI = 'h110;
  localparam int OFF_IE     = 'h114;
  localparam int OFF_STAT   = 'h118;
  localparam int OFF_TEST   = 'h11C;

  localparam int CNT_W      = 64;
  localparam int STEP_LSB   = 16;

  // Count after one tick.
  function automatic logic [CNT_W-1:0] f_advance(input logic [CNT_W-1:0] cnt,
                                                 input logic [7:0] inc);
    return cnt + CNT_W'(inc);
  endfunction

  // True when the count has reached the compare value.
  function automatic logic f_reached(input logic [CNT_W-1:0] cnt,
                                     input logic [CNT_W-1:0] cmp);
    return cnt >= cmp;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] limit_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] div_q;

  assign tick_o = run_i && (div_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              div_q <= '0;
    else if (!run_i || tick_o) div_q <= '0;
    else                      div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CW = 64,
  parameter int SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [SW-1:0] inc_i,
  output logic [CW-1:0] count_o
);
  import tmr_pkg::*;

  logic [CW-1:0] cnt_q;
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= f_advance(cnt_q, inc_i);
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int ADDR_W = 12,
  parameter int DW     = 32,
  parameter int PRE_W  = 12,
  parameter int SW     = 8,
  localparam int CW    = 2 * DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [CW-1:0]     count_i,
  input  logic              hit_i,
  output logic              run_o,
  output logic [PRE_W-1:0]  limit_o,
  output logic [SW-1:0]     inc_o,
  output logic [CW-1:0]     cmp_o,
  output logic              ien_o,
  output logic              st_o,
  output logic              st_set_o,
  output logic              st_clr_o
);
  import tmr_pkg::*;

  logic          run_q, ien_q, st_q;
  logic [PRE_W-1:0] lim_q;
  logic [SW-1:0] inc_q;
  logic [DW-1:0] cmp_lo_q, cmp_hi_q;
  logic          wr;

  assign wr = req_i && we_i;

  function automatic logic at(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  assign st_set_o = ien_q && ((run_q && hit_i) ||
                    (wr && at(addr_i, OFF_TEST) && wdata_i[0]));
  assign st_clr_o = wr && at(addr_i, OFF_STAT) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      lim_q    <= '0;
      inc_q    <= SW'(1);
      cmp_lo_q <= '1;
      cmp_hi_q <= '1;
      ien_q    <= 1'b0;
      st_q     <= 1'b0;
    end else begin
      if (wr && at(addr_i, OFF_CTRL))   run_q <= wdata_i[0];
      if (wr && at(addr_i, OFF_CFG)) begin
        lim_q <= wdata_i[PRE_W-1:0];
        inc_q <= wdata_i[STEP_LSB +: SW];
      end
      if (wr && at(addr_i, OFF_CMP_LO)) cmp_lo_q <= wdata_i;
      if (wr && at(addr_i, OFF_CMP_HI)) cmp_hi_q <= wdata_i;
      if (wr && at(addr_i, OFF_IE))     ien_q <= wdata_i[0];
      if (st_set_o)      st_q <= 1'b1;
      else if (st_clr_o) st_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (at(addr_i, OFF_CTRL))   rdata_o = DW'(run_q);
      if (at(addr_i, OFF_CFG))    rdata_o = (DW'(inc_q) << STEP_LSB) | DW'(lim_q);
      if (at(addr_i, OFF_CNT_LO)) rdata_o = count_i[DW-1:0];
      if (at(addr_i, OFF_CNT_HI)) rdata_o = count_i[CW-1:DW];
      if (at(addr_i, OFF_CMP_LO)) rdata_o = cmp_lo_q;
      if (at(addr_i, OFF_CMP_HI)) rdata_o = cmp_hi_q;
      if (at(addr_i, OFF_IE))     rdata_o = DW'(ien_q);
      if (at(addr_i, OFF_STAT))   rdata_o = DW'(st_q);
    end
  end

  assign run_o   = run_q;
  assign limit_o = lim_q;
  assign inc_o   = inc_q;
  assign cmp_o   = {cmp_hi_q, cmp_lo_q};
  assign ien_o   = ien_q;
  assign st_o    = st_q;
endmodule

// File: rtl/tick_timer64.sv
module tick_timer64 #(
  parameter int ADDR_W = 12,
  parameter int DW     = 32,
  parameter int PRE_W  = 12,
  parameter int SW     = 8,
  localparam int CW    = 2 * DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              mtip_o,
  output logic              irq_o
);
  import tmr_pkg::*;

  logic             run, tick, hit, ien, st, st_set, st_clr, mtip_q;
  logic [PRE_W-1:0] limit;
  logic [SW-1:0]    inc;
  logic [CW-1:0]    count, cmp;

  tmr_regs #(.ADDR_W(ADDR_W), .DW(DW), .PRE_W(PRE_W), .SW(SW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .count_i(count), .hit_i(hit), .run_o(run), .limit_o(limit),
    .inc_o(inc), .cmp_o(cmp), .ien_o(ien), .st_o(st),
    .st_set_o(st_set), .st_clr_o(st_clr)
  );

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .limit_i(limit), .tick_o(tick)
  );

  tmr_counter #(.CW(CW), .SW(SW)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .inc_i(inc), .count_o(count)
  );

  assign hit = f_reached(count, cmp);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  mtip_q <= 1'b0;
    else if (run) mtip_q <= hit;
  end

  assign mtip_o = mtip_q;
  assign irq_o  = st && ien;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int CW = 64,
  parameter int SW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          run,
  input logic          tick,
  input logic          hit,
  input logic [CW-1:0] count,
  input logic [SW-1:0] inc,
  input logic          ien,
  input logic          st,
  input logic          st_set,
  input logic          st_clr,
  input logic          mtip_o,
  input logic          irq_o
);
  // R3
  hold_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> $stable(count));
  // R3
  hold_mtip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> $stable(mtip_o));
  // R5
  step_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> count == $past(count) + CW'($past(inc)));
  // R6
  raw_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && hit |=> mtip_o);
  // R7
  latch_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_set |=> st);
  // R8
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_clr && !st_set |=> !st);
  // R10
  gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ien);
endmodule

bind tick_timer64 tmr_chk #(.CW(CW), .SW(SW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run(run), .tick(tick), .hit(hit),
  .count(count), .inc(inc), .ien(ien), .st(st), .st_set(st_set),
  .st_clr(st_clr), .mtip_o(mtip_o), .irq_o(irq_o)
);

// File: tb/sim_tick_timer64.sv
`timescale 1ns/1ps
module sim_tick_timer64;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        mtip, irq;
  int          n_run = 0, n_fail = 0;

  localparam logic [11:0] A_CTRL = 12'h004, A_CFG = 12'h100, A_CLO = 12'h104,
    A_CHI = 12'h108, A_KLO = 12'h10C, A_KHI = 12'h110, A_IE = 12'h114,
    A_ST = 12'h118, A_TST = 12'h11C, A_NONE = 12'h200, A_ZERO = 12'h000;

  always #4 clk = ~clk;

  tick_timer64 u0 (.clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .mtip_o(mtip), .irq_o(irq));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drives one write; called at a falling edge, returns at the next one.
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_CFG, v);  chk("R1 cfg", v, 32'h0001_0000);
    rd(A_KLO, v);  chk("R1 cmp lo", v, 32'hFFFF_FFFF);
    rd(A_KHI, v);  chk("R1 cmp hi", v, 32'hFFFF_FFFF);
    rd(A_IE, v);   chk("R1 ie", v, 0);
    rd(A_ST, v);   chk("R1 status", v, 0);
    chk("R1 outputs", {mtip, irq}, 0);
  endtask

  task automatic t_stopped();
    logic [31:0] v;
    repeat (20) @(negedge clk);
    rd(A_CLO, v); chk("R3 count frozen", v, 0);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    int w = 39, p = 3, s = 5;
    wr(A_CFG, 32'hAB05_F003);
    rd(A_CFG, v); chk("R2 cfg fields", v, 32'h0005_0003);
    wr(A_CTRL, 1);
    repeat (w) @(negedge clk);
    wr(A_CTRL, 0);
    rd(A_CLO, v); chk("R4 R5 count after prescaled run", v, ((w + 1) / (p + 1)) * s);
    rd(A_CHI, v); chk("R2 count hi", v, 0);
    wr(A_CLO, 32'hDEAD);
    wr(A_CHI, 32'h1);
    rd(A_CLO, v); chk("R5 count write ignored lo", v, 50);
    rd(A_CHI, v); chk("R5 count write ignored hi", v, 0);
  endtask

  task automatic t_compare();
    logic [31:0] v;
    bit seen = 0;
    wr(A_CFG, 32'h0001_0000);
    wr(A_KHI, 0);
    wr(A_KLO, 100);
    wr(A_IE, 1);
    wr(A_CTRL, 1);
    for (int i = 0; i < 200 && !seen; i++) begin
      if (mtip) begin
        seen = 1;
        rd(A_CLO, v);
        chk("R6 count at raw rise", v, 101);
        chk("R7 irq with compare", irq, 1);
      end else @(negedge clk);
    end
    chk("R6 raw rose", seen, 1);
    wr(A_CTRL, 0);
  endtask

  task automatic t_move_cmp();
    logic [31:0] v;
    wr(A_KLO, 1000);
    repeat (3) @(negedge clk);
    chk("R3 raw frozen while stopped", mtip, 1);
    wr(A_CTRL, 1);
    chk("R6 raw still high on start edge", mtip, 1);
    @(negedge clk);
    chk("R6 raw fell", mtip, 0);
    wr(A_CTRL, 0);
    rd(A_ST, v); chk("R7 status latched", v, 1);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(A_ST, 0);
    rd(A_ST, v); chk("R8 zero write keeps", v, 1);
    wr(A_ST, 32'hFFFF_FFFF);
    rd(A_ST, v); chk("R8 one clears", v, 0);
    chk("R8 irq low", irq, 0);
  endtask

  task automatic t_force();
    logic [31:0] v;
    wr(A_IE, 0);
    wr(A_TST, 1);
    rd(A_ST, v); chk("R9 test ignored when disabled", v, 0);
    chk("R9 irq low", irq, 0);
    wr(A_IE, 1);
    wr(A_TST, 1);
    rd(A_ST, v); chk("R9 test sets", v, 1);
    chk("R9 irq high", irq, 1);
    rd(A_TST, v); chk("R9 test reads zero", v, 0);
    wr(A_IE, 0);
    chk("R10 masked", irq, 0);
    rd(A_ST, v); chk("R10 status kept", v, 1);
    wr(A_IE, 1);
    chk("R10 unmasked", irq, 1);
    wr(A_ST, 1);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    rd(A_NONE, v); chk("R11 unmapped read", v, 0);
    rd(A_ZERO, v); chk("R11 offset zero read", v, 0);
    wr(A_NONE, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R11 ctrl untouched", v, 0);
    rd(A_CFG, v);  chk("R11 cfg untouched", v, 32'h0001_0000);
    rd(A_ST, v);   chk("R11 status untouched", v, 0);
  endtask

  task automatic t_half();
    wr(A_KHI, 1);
    wr(A_KLO, 0);
    wr(A_CTRL, 1);
    @(negedge clk); @(negedge clk);
    chk("R12 raw low with hi=1", mtip, 0);
    wr(A_KHI, 0);
    @(negedge clk);
    chk("R12 raw high after hi-only write", mtip, 1);
    wr(A_CTRL, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stopped();
    t_prescale();
    t_compare();
    t_move_cmp();
    t_w1c();
    t_force();
    t_unmapped();
    t_half();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule